// File: doc/BRIEF.md
# Serial Peripheral Master with Receive Compare and Word FIFOs

This block is a serial peripheral interface master. Software-style configuration inputs pick the frame size (8 or 16 bits), the bit order on the wire, the clock polarity and phase, and a half-period divider for the serial clock. Words written into a transmit FIFO are sent one at a time. For each word the block pulls its chip-select output low, clocks the frame out on the data output while capturing the data input, releases chip-select, and stores the captured word in a receive FIFO.

Each FIFO holds 64 bits of payload: four words in 16-bit mode or eight words in 8-bit mode. Every captured word is compared with a programmed compare value and a sticky flag records a hit. A second master on the bus is detected through a chip-select sense input. When that input is pulled low, the block raises a fault flag, abandons the frame in flight and stays off the bus until the fault is cleared. The three sticky flags (compare hit, fault, write overflow) are combined into one interrupt line.

Top module: `spim_top`

## Requirements
- R1: `ss_n` is low exactly while a frame is in progress. It is high after reset and between frames, and stays high for at least one clock between two frames.
- R2: While `cfg_enable` is 1, a low level on `ss_in_n` sets `modf_flag` three clocks later (two synchronizer stages, then the flag). From the clock after the flag is set, `ss_n` is high, `sck` sits at its idle level and the aborted frame is not stored. No frame starts until `ss_in_n` is high again and `modf_clr` has been pulsed.
- R3: With `cfg_lsb_first`=0 the word goes out most significant bit first. With 1 it goes out bit 0 first. Captured bits are placed back in the same order, so a looped-back word reads back unchanged.
- R4: `sck` idles at `cfg_cpol`. With `cfg_cpha`=0, data is sampled on the first (leading) edge of each clock period. With `cfg_cpha`=1, it is sampled on the second (trailing) edge. Each `sck` half-period is max(`cfg_div`,1) clocks, and `ss_n` stays low for (2N+1)·max(`cfg_div`,1) clocks, where N is the frame size.
- R5: `cfg_len16`=1 sends 16 bits per frame and `cfg_len16`=0 sends 8 bits. In 8-bit mode bits 15:8 of the transmit word are ignored and read back as 0.
- R6: The FIFO limit is 4 words in 16-bit mode and 8 words in 8-bit mode. `tx_full` is 1 at the limit. A write at the limit is dropped and sets `ovf_flag`, which `ovf_clr` clears.
- R7: `rx_data` shows the oldest received word, and a pulse on `rx_rd` removes it. When the receive FIFO is empty, `rx_data` is 0 and `rx_rd` has no effect.
- R8: A stored word equal to `cfg_match` sets `match_flag`, which `match_clr` clears. In 8-bit mode only bits 7:0 of `cfg_match` are compared.
- R9: `irq` is 1 while any of `match_flag`, `modf_flag` or `ovf_flag` is 1.
- R10: A frame starts only while the transmit FIFO is not empty and the receive FIFO is below its limit. Otherwise the pending word waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Allows frames to start and enables fault sensing |
| cfg_len16 | input | 1 | 1: 16-bit frames, 0: 8-bit frames |
| cfg_lsb_first | input | 1 | 1: bit 0 first on the wire |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_div | input | DIV_W | Half-period of `sck` in clocks (0 acts as 1) |
| cfg_match | input | 16 | Compare value for received words |
| tx_wr | input | 1 | Write strobe for the transmit FIFO |
| tx_data | input | 16 | Word to transmit |
| tx_level | output | $clog2(FIFO_BITS/8+1) | Words in the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO at its limit |
| rx_rd | input | 1 | Removes the oldest received word |
| rx_data | output | 16 | Oldest received word, 0 when empty |
| rx_level | output | $clog2(FIFO_BITS/8+1) | Words in the receive FIFO |
| rx_empty | output | 1 | Receive FIFO is empty |
| match_clr | input | 1 | Clears `match_flag` |
| match_flag | output | 1 | A received word equalled the compare value |
| modf_clr | input | 1 | Clears `modf_flag` |
| modf_flag | output | 1 | Another master pulled `ss_in_n` low |
| ovf_clr | input | 1 | Clears `ovf_flag` |
| ovf_flag | output | 1 | A transmit write was dropped |
| irq | output | 1 | OR of the three flags |
| busy | output | 1 | A frame is in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out (0 when idle) |
| ss_n | output | 1 | Chip select, active low |
| miso | input | 1 | Serial data in |
| ss_in_n | input | 1 | Chip-select sense for fault detection |

## Verification
The bench builds the block with its defaults: FIFO_BITS of 64 and an 8-bit divider field. Under these defaults a handful of writes reaches both FIFO limits (four and eight words), and the bench also switches frame size while running. The divider is varied at run time through 0, 1, 2 and 3. This covers the zero-as-one rule and checks that chip-select low time scales with the half-period. A loopback with optional inversion from the data output to the data input lets each frame check bit order, frame size and the receive path together.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int MAX_W = 16;
  localparam int MIN_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} spim_state_t;

  function automatic logic [MAX_W-1:0] rev_word(input logic [MAX_W-1:0] v);
    logic [MAX_W-1:0] r;
    for (int i = 0; i < MAX_W; i++) r[i] = v[MAX_W-1-i];
    return r;
  endfunction

  // Place the first bit to be sent at the top of the shift register.
  function automatic logic [MAX_W-1:0] tx_align(input logic [MAX_W-1:0] d,
                                                input logic len16, input logic lsb);
    if (lsb) return rev_word(d);
    if (len16) return d;
    return {d[MIN_W-1:0], {(MAX_W-MIN_W){1'b0}}};
  endfunction

  // Captured bits arrive with the first one highest; put them back in word order.
  function automatic logic [MAX_W-1:0] rx_align(input logic [MAX_W-1:0] raw,
                                                input logic len16, input logic lsb);
    logic [MAX_W-1:0] r;
    r = rev_word(raw);
    if (lsb && len16) return r;
    if (lsb) return {{(MAX_W-MIN_W){1'b0}}, r[MAX_W-1 -: MIN_W]};
    if (len16) return raw;
    return {{(MAX_W-MIN_W){1'b0}}, raw[MIN_W-1:0]};
  endfunction

  function automatic logic word_match(input logic [MAX_W-1:0] w,
                                      input logic [MAX_W-1:0] ref_v, input logic len16);
    if (len16) return w == ref_v;
    return w[MIN_W-1:0] == ref_v[MIN_W-1:0];
  endfunction

  function automatic logic [4:0] last_edge(input logic len16);
    return len16 ? 5'(2*MAX_W-1) : 5'(2*MIN_W-1);
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH+1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] limit,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = count >= limit;
  assign empty   = count == '0;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             halt,
  input  logic [MAX_W-1:0] tx_word,
  input  logic             cfg_len16,
  input  logic             cfg_lsb_first,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             miso,
  output logic             xfer_done,
  output logic [MAX_W-1:0] rx_word,
  output logic             busy,
  output logic             sck,
  output logic             mosi,
  output logic             ss_n
);
  spim_state_t      state;
  logic [DIV_W-1:0] hcnt, half_m1;
  logic [4:0]       edge_n;
  logic [MAX_W-1:0] tx_sr, rx_sr;
  logic             sck_r, tick, lead, do_sample, do_shift, at_last;

  assign half_m1   = (cfg_div == '0) ? '0 : cfg_div - 1'b1;
  assign tick      = (state != ST_IDLE) && (hcnt == half_m1);
  assign lead      = !edge_n[0];
  assign at_last   = edge_n == last_edge(cfg_len16);
  assign do_sample = lead ^ cfg_cpha;
  assign do_shift  = !do_sample && (cfg_cpha ? (edge_n != '0) : !at_last);

  assign busy      = state != ST_IDLE;
  assign sck       = cfg_cpol ^ sck_r;
  assign mosi      = busy ? tx_sr[MAX_W-1] : 1'b0;
  assign xfer_done = (state == ST_TAIL) && tick && !halt;
  assign rx_word   = rx_align(rx_sr, cfg_len16, cfg_lsb_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hcnt   <= '0;
      edge_n <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      sck_r  <= 1'b0;
      ss_n   <= 1'b1;
    end else if (halt) begin
      state <= ST_IDLE;
      hcnt  <= '0;
      sck_r <= 1'b0;
      ss_n  <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_SHIFT;
          ss_n   <= 1'b0;
          hcnt   <= '0;
          edge_n <= '0;
          rx_sr  <= '0;
          tx_sr  <= tx_align(tx_word, cfg_len16, cfg_lsb_first);
        end
        ST_SHIFT: if (tick) begin
          hcnt  <= '0;
          sck_r <= ~sck_r;
          if (do_sample) rx_sr <= {rx_sr[MAX_W-2:0], miso};
          if (do_shift)  tx_sr <= {tx_sr[MAX_W-2:0], 1'b0};
          if (at_last) state <= ST_TAIL;
          else         edge_n <= edge_n + 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
        ST_TAIL: if (tick) begin
          state <= ST_IDLE;
          hcnt  <= '0;
          ss_n  <= 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int FIFO_BITS = 64,
  parameter int DIV_W     = 8,
  localparam int DEPTH    = FIFO_BITS / MIN_W,
  localparam int CW       = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_len16,
  input  logic             cfg_lsb_first,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [MAX_W-1:0] cfg_match,
  input  logic             tx_wr,
  input  logic [MAX_W-1:0] tx_data,
  output logic [CW-1:0]    tx_level,
  output logic             tx_full,
  input  logic             rx_rd,
  output logic [MAX_W-1:0] rx_data,
  output logic [CW-1:0]    rx_level,
  output logic             rx_empty,
  input  logic             match_clr,
  output logic             match_flag,
  input  logic             modf_clr,
  output logic             modf_flag,
  input  logic             ovf_clr,
  output logic             ovf_flag,
  output logic             irq,
  output logic             busy,
  output logic             sck,
  output logic             mosi,
  output logic             ss_n,
  input  logic             miso,
  input  logic             ss_in_n
);
  logic [CW-1:0]    limit;
  logic [MAX_W-1:0] tx_head, rx_word;
  logic             tx_empty, rx_full, xfer_start, xfer_done;
  logic             ss_s1, ss_s2, modf_set, ovf_set, match_set;

  assign limit = cfg_len16 ? CW'(FIFO_BITS / MAX_W) : CW'(DEPTH);

  // Named events
  assign xfer_start = cfg_enable && !modf_flag && !busy && !tx_empty && !rx_full;
  assign modf_set   = cfg_enable && !ss_s2;
  assign ovf_set    = tx_wr && tx_full;
  assign match_set  = xfer_done && word_match(rx_word, cfg_match, cfg_len16);
  assign irq        = match_flag || modf_flag || ovf_flag;

  spim_fifo #(.W(MAX_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_wr), .pop(xfer_start), .din(tx_data),
    .limit(limit), .dout(tx_head), .count(tx_level), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(MAX_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(xfer_done), .pop(rx_rd), .din(rx_word),
    .limit(limit), .dout(rx_data), .count(rx_level), .full(rx_full), .empty(rx_empty));

  spim_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .halt(modf_flag), .tx_word(tx_head),
    .cfg_len16(cfg_len16), .cfg_lsb_first(cfg_lsb_first), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .miso(miso), .xfer_done(xfer_done),
    .rx_word(rx_word), .busy(busy), .sck(sck), .mosi(mosi), .ss_n(ss_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_s1      <= 1'b1;
      ss_s2      <= 1'b1;
      modf_flag  <= 1'b0;
      ovf_flag   <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      ss_s1      <= ss_in_n;
      ss_s2      <= ss_s1;
      modf_flag  <= modf_set  ? 1'b1 : (modf_clr  ? 1'b0 : modf_flag);
      ovf_flag   <= ovf_set   ? 1'b1 : (ovf_clr   ? 1'b0 : ovf_flag);
      match_flag <= match_set ? 1'b1 : (match_clr ? 1'b0 : match_flag);
    end
  end
endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
#(
  parameter int FIFO_BITS = 64,
  localparam int DEPTH    = FIFO_BITS / MIN_W,
  localparam int CW       = $clog2(DEPTH+1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_len16,
  input logic             cfg_cpol,
  input logic [MAX_W-1:0] cfg_match,
  input logic             busy,
  input logic             ss_n,
  input logic             sck,
  input logic             modf_flag,
  input logic             tx_wr,
  input logic             tx_full,
  input logic             ovf_flag,
  input logic [CW-1:0]    tx_level,
  input logic [CW-1:0]    rx_level,
  input logic             rx_empty,
  input logic [MAX_W-1:0] rx_data,
  input logic             xfer_start,
  input logic             xfer_done,
  input logic [MAX_W-1:0] rx_word,
  input logic             match_flag
);
  logic [CW-1:0] lim;
  assign lim = cfg_len16 ? CW'(FIFO_BITS / MAX_W) : CW'(DEPTH);

  AST_SS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) busy == !ss_n); // R1
  AST_FAULT_HALT: assert property (@(posedge clk) disable iff (!rst_n) modf_flag |=> ss_n); // R2
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ss_n |-> sck == cfg_cpol); // R4
  AST_TX_CAP: assert property (@(posedge clk) disable iff (!rst_n) tx_level <= lim); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) tx_wr && tx_full |=> ovf_flag); // R6
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rx_empty |-> rx_data == '0); // R7
  AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && word_match(rx_word, cfg_match, cfg_len16) |=> match_flag); // R8
  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> tx_level != '0 && rx_level < lim && !modf_flag); // R10
endmodule

bind spim_top spim_checker #(.FIFO_BITS(FIFO_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_len16(cfg_len16), .cfg_cpol(cfg_cpol),
  .cfg_match(cfg_match), .busy(busy), .ss_n(ss_n), .sck(sck), .modf_flag(modf_flag),
  .tx_wr(tx_wr), .tx_full(tx_full), .ovf_flag(ovf_flag), .tx_level(tx_level),
  .rx_level(rx_level), .rx_empty(rx_empty), .rx_data(rx_data), .xfer_start(xfer_start),
  .xfer_done(xfer_done), .rx_word(rx_word), .match_flag(match_flag));

// File: tb/spim_top_test.sv
module spim_top_test;
  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_len16 = 1, cfg_lsb_first = 0, cfg_cpol = 0, cfg_cpha = 0;
  logic [7:0]  cfg_div = 1;
  logic [15:0] cfg_match = 16'hFFFF;
  logic tx_wr = 0, rx_rd = 0, match_clr = 0, modf_clr = 0, ovf_clr = 0, ss_in_n = 1;
  logic [15:0] tx_data = 0;
  logic [3:0]  tx_level, rx_level;
  logic [15:0] rx_data;
  logic tx_full, rx_empty, match_flag, modf_flag, ovf_flag, irq, busy, sck, mosi, ss_n, miso;
  logic miso_inv = 0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  assign miso = mosi ^ miso_inv;

  spim_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_len16(cfg_len16),
    .cfg_lsb_first(cfg_lsb_first), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .cfg_match(cfg_match), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_level(tx_level), .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_level(rx_level), .rx_empty(rx_empty), .match_clr(match_clr), .match_flag(match_flag),
    .modf_clr(modf_clr), .modf_flag(modf_flag), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
    .irq(irq), .busy(busy), .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso),
    .ss_in_n(ss_in_n));

  // Wire monitor: collects data-out bits on the sampling edges of the selected mode.
  logic [15:0] mon_bits = 0;
  int mon_cnt = 0;
  logic ss_seen = 1;
  always @(sck, ss_n) begin
    if (ss_n != ss_seen) begin
      if (!ss_n) begin mon_bits = 0; mon_cnt = 0; end
      ss_seen = ss_n;
    end else if (!ss_n) begin
      if ((sck != cfg_cpol) == !cfg_cpha) begin
        mon_bits = {mon_bits[14:0], mosi};
        mon_cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rev_n(input logic [15:0] v, input int n);
    logic [15:0] r = 0;
    for (int i = 0; i < n; i++) r[n-1-i] = v[i];
    return r;
  endfunction

  task automatic push_word(input logic [15:0] d);
    @(negedge clk) tx_wr = 1; tx_data = d;
    @(negedge clk) tx_wr = 0;
  endtask

  task automatic pop_word();
    @(negedge clk) rx_rd = 1;
    @(negedge clk) rx_rd = 0;
  endtask

  task automatic wait_quiet();
    do @(negedge clk); while (busy || tx_level != 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ss_n after reset", ss_n, 1);
    chk("R4 sck idle after reset", sck, 0);
    chk("R6 tx_level after reset", tx_level, 0);
    chk("R7 rx_data after reset", rx_data, 0);
    chk("R9 irq after reset", irq, 0);
  endtask

  // One looped-back frame in the current mode; checks wire order, size, timing and readback.
  task automatic t_frame(input logic [15:0] d, input logic inv, input string tag);
    int n = cfg_len16 ? 16 : 8;
    int h = (cfg_div == 0) ? 1 : int'(cfg_div);
    logic [15:0] mask = cfg_len16 ? 16'hFFFF : 16'h00FF;
    logic [15:0] wire_exp = cfg_lsb_first ? rev_n(d, n) : (d & mask);
    int low = 0;
    miso_inv = inv;
    @(negedge clk) tx_wr = 1; tx_data = d;
    @(negedge clk) tx_wr = 0;
    do begin
      if (!ss_n) low++;
      @(negedge clk);
    end while (busy || tx_level != 0);
    @(negedge clk);
    chk({"R3 wire bit order ", tag}, mon_bits & mask, wire_exp);
    chk({"R5 bits per frame ", tag}, mon_cnt, n);
    chk({"R4 ss_n low cycles ", tag}, low, (2*n+1)*h);
    chk({"R1 ss_n released ", tag}, ss_n, 1);
    chk({"R5 R3 readback ", tag}, rx_data, (d ^ (inv ? 16'hFFFF : 16'h0)) & mask);
    pop_word();
    miso_inv = 0;
  endtask

  task automatic t_modes();
    cfg_enable = 1;
    cfg_cpol = 0; cfg_cpha = 0; cfg_len16 = 1; cfg_lsb_first = 0; cfg_div = 1;
    t_frame(16'hA5C3, 0, "mode0");
    cfg_cpol = 0; cfg_cpha = 1; cfg_len16 = 0; cfg_lsb_first = 1; cfg_div = 2;
    t_frame(16'h12B4, 0, "mode1");
    cfg_cpol = 1; cfg_cpha = 0; cfg_len16 = 1; cfg_lsb_first = 1; cfg_div = 3;
    @(negedge clk);
    chk("R4 sck idles high with cpol", sck, 1);
    t_frame(16'h8E21, 1, "mode2");
    cfg_cpol = 1; cfg_cpha = 1; cfg_len16 = 0; cfg_lsb_first = 0; cfg_div = 0;
    t_frame(16'hFF6D, 1, "mode3");
    cfg_cpol = 0; cfg_cpha = 0; cfg_div = 1;
  endtask

  task automatic t_capacity();
    cfg_enable = 0; cfg_len16 = 1;
    for (int i = 0; i < 5; i++) push_word(16'h1000 + 16'(i));
    chk("R6 tx limit 16-bit", tx_level, 4);
    chk("R6 tx_full", tx_full, 1);
    chk("R6 overflow flag", ovf_flag, 1);
    chk("R9 irq from overflow", irq, 1);
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
    chk("R6 overflow cleared", ovf_flag, 0);
    cfg_enable = 1;
    wait_quiet();
    for (int i = 0; i < 4; i++) begin
      chk("R7 rx order 16-bit", rx_data, 16'h1000 + 16'(i));
      pop_word();
    end
    chk("R7 rx empty after drain", rx_empty, 1);
    cfg_enable = 0; cfg_len16 = 0;
    for (int i = 0; i < 9; i++) push_word(16'h0010 + 16'(i));
    chk("R6 tx limit 8-bit", tx_level, 8);
    chk("R6 overflow 8-bit", ovf_flag, 1);
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
    cfg_enable = 1;
    wait_quiet();
    chk("R10 rx at limit", rx_level, 8);
    push_word(16'h0020);
    repeat (60) @(negedge clk);
    chk("R10 frame held while rx full", tx_level, 1);
    chk("R10 no chip select while rx full", ss_n, 1);
    chk("R7 oldest word", rx_data, 16'h0010);
    pop_word();
    wait_quiet();
    chk("R10 held frame resumed", rx_level, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R7 rx order 8-bit", rx_data, (i == 7) ? 16'h0020 : 16'h0011 + 16'(i));
      pop_word();
    end
  endtask

  task automatic t_empty_read();
    pop_word();
    chk("R7 empty read data", rx_data, 0);
    chk("R7 empty read level", rx_level, 0);
  endtask

  task automatic t_match();
    cfg_len16 = 1; cfg_match = 16'hA55A;
    t_frame(16'h1234, 0, "nomatch16");
    chk("R8 no match 16-bit", match_flag, 0);
    t_frame(16'hA55A, 0, "match16");
    chk("R8 match 16-bit", match_flag, 1);
    chk("R9 irq from match", irq, 1);
    @(negedge clk) match_clr = 1;
    @(negedge clk) match_clr = 0;
    chk("R8 match cleared", match_flag, 0);
    cfg_len16 = 0; cfg_match = 16'h775A;
    t_frame(16'h005B, 0, "nomatch8");
    chk("R8 no match 8-bit", match_flag, 0);
    t_frame(16'h005A, 0, "match8");
    chk("R8 low byte match 8-bit", match_flag, 1);
    @(negedge clk) match_clr = 1;
    @(negedge clk) match_clr = 0;
  endtask

  task automatic t_fault();
    cfg_len16 = 1; cfg_div = 4; cfg_cpol = 1;
    push_word(16'hC0DE);
    repeat (20) @(negedge clk);
    chk("R1 frame in progress", ss_n, 0);
    ss_in_n = 0;
    repeat (2) @(negedge clk);
    chk("R2 flag not before sync", modf_flag, 0);
    @(negedge clk);
    chk("R2 fault flag", modf_flag, 1);
    @(negedge clk);
    chk("R2 chip select released", ss_n, 1);
    chk("R2 sck idle on fault", sck, 1);
    chk("R9 irq from fault", irq, 1);
    push_word(16'h4321);
    repeat (60) @(negedge clk);
    chk("R2 halted while fault set", ss_n, 1);
    chk("R2 aborted word not stored", rx_level, 0);
    chk("R2 pending word kept", tx_level, 1);
    ss_in_n = 1;
    repeat (4) @(negedge clk);
    modf_clr = 1;
    @(negedge clk) modf_clr = 0;
    chk("R2 fault cleared", modf_flag, 0);
    wait_quiet();
    chk("R2 resumes after clear", rx_data, 16'h4321);
    pop_word();
    cfg_cpol = 0; cfg_div = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_capacity();
    t_empty_read();
    t_match();
    t_fault();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule